// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Register

This block holds the status byte of a serial flash device and decides whether each write-type instruction may go ahead. The instruction decoder presents one decoded instruction per cycle on a small op-code bus, along with the status byte that a status write carries and the block index that a program or erase targets. In the same cycle the block answers with a one-hot grant for the operation it accepts, or a refuse pulse if it turns the operation down. A grant starts the internal program/erase engine. The block then shows itself busy until the engine signals completion.

The status byte is always readable. Its persistent fields are the protect level, the quad-mode select and the hardware lock enable. They are ordinary registers that keep their value and clear on reset. Three checks guard the write path. The write-enable latch must be set, and it clears itself when each operation finishes. The lock enable combined with a low write-protect pin freezes the persistent fields. The protect level fences off the top of the array and blocks a whole-chip erase. When quad mode is selected, the write-protect and hold pins are switched over to data use, and the lock then treats the pin as inactive.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, every status bit reads 0 and `io23_data_mode` is 0.
- R2: The status byte reads as bit 7 lock enable, bit 6 quad select, bits 5:2 protect level, bit 1 write-enable latch (WEL), bit 0 busy (WIP).
- R3: When the block is idle, op 1 sets WEL and op 2 clears WEL from the next cycle on. Op-code map: 0 none, 1 set latch, 2 clear latch, 3 status write, 4 configuration write, 5 page program, 6 sector erase, 7 block erase, 8 chip erase.
- R4: The write-type ops 3 to 8 get a one-hot grant in the same cycle (`grant_vec` bit 0 status write, 1 configuration write, 2 page program, 3 sector erase, 4 block erase, 5 chip erase). A write-type op is refused with a `refuse` pulse whenever WEL is 0.
- R5: A grant sets WIP from the next cycle. `eng_done` while WIP is 1 clears both WIP and WEL on the next cycle. `eng_done` while idle has no effect.
- R6: While WIP is 1, ops 1 and 2 have no effect and every write-type op is refused.
- R7: A granted status write loads bits 7:2 of `cmd_data` into the persistent fields. Bits 1:0 of the data are ignored.
- R8: When the lock enable is 1, quad select is 0 and `wp_n` is 0, a status write is refused and the persistent fields stay unchanged. With `wp_n` high or the lock enable at 0, the status write is accepted.
- R9: When quad select is 1, `io23_data_mode` is 1 and the lock check treats `wp_n` as high.
- R10: A chip erase is refused unless the protect level is 0.
- R11: A protect level n in 1..5 covers blocks 32−2^(n−1) to 31. A level of 6 or more covers all 32 blocks. A page program, sector erase or block erase whose `cmd_blk` lies in the covered range is refused.
- R12: A refused operation leaves WEL unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 4 | Decoded instruction code, one per cycle |
| cmd_data | input | 8 | Data byte carried by a status write |
| cmd_blk | input | 5 | Target block index of a program or erase |
| wp_n | input | 1 | Write-protect pin level |
| eng_done | input | 1 | Program/erase engine completion pulse |
| sr_rd | output | 8 | Current status byte |
| grant_vec | output | 6 | One-hot grant per write-type operation |
| refuse | output | 1 | Write-type operation turned down this cycle |
| io23_data_mode | output | 1 | 1 when the protect and hold pins carry data |

## Verification
The bench goes after the edges of the protected range: block 27 against block 28 at level 3, block 15 against block 16 at level 5, and block 0 at level 6. An off-by-one region decoder would grant an erase into a protected block, or refuse one just outside the range. It sets the lock enable and drives the pin low both with and without quad select. A design that ignored the quad override would wrongly freeze the register, and one that ignored the pin would never freeze it. It sends latch and write instructions while the device is busy, a completion pulse while idle, and refused operations with the latch set. A latch that leaked in any of these cases would show up as a wrong bit 1 in the status byte read back.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   typedef enum logic [3:0] {
      OP_NONE    = 4'd0,
      OP_WEL_SET = 4'd1,
      OP_WEL_CLR = 4'd2,
      OP_STAT_WR = 4'd3,
      OP_CFG_WR  = 4'd4,
      OP_PROG    = 4'd5,
      OP_SECT_ER = 4'd6,
      OP_BLK_ER  = 4'd7,
      OP_CHIP_ER = 4'd8
   } op_e;

   // write-type operations, grant vector order follows op code order
   localparam int WOP_N     = 6;
   localparam int GI_STAT   = 0;
   localparam int GI_CFG    = 1;
   localparam int GI_PROG   = 2;
   localparam int GI_SECT   = 3;
   localparam int GI_BLK    = 4;
   localparam int GI_CHIP   = 5;

   // status byte layout
   localparam int SR_W      = 8;
   localparam int SB_WIP    = 0;
   localparam int SB_WEL    = 1;
   localparam int SB_LVL_LO = 2;
   localparam int LVL_W     = 4;
   localparam int SB_QSEL   = 6;
   localparam int SB_LOCK   = 7;

   function automatic logic [3:0] gidx_to_op(input int gidx);
      return 4'(int'(OP_STAT_WR) + gidx);
   endfunction

endpackage

// File: rtl/fsr_prot_decode.sv
module fsr_prot_decode
   import fsr_pkg::*;
#(
   parameter int BLK_W    = 5,
   parameter bit FROM_TOP = 1'b1
) (
   input  logic [LVL_W-1:0] lvl,
   input  logic [BLK_W-1:0] blk,
   output logic             lvl_any,
   output logic             blk_hit
);

   localparam int SPAN_W = BLK_W + 1;
   localparam logic [SPAN_W-1:0] NBLK_V = SPAN_W'(1) << BLK_W;

   if (BLK_W < 1 || BLK_W > 16) begin : g_bad_blk_w
      $error("fsr_prot_decode: BLK_W out of range");
   end

   logic [SPAN_W-1:0] span;
   logic [SPAN_W-1:0] blk_ext;

   assign blk_ext = {1'b0, blk};
   assign lvl_any = (lvl != '0);

   always_comb begin
      if (lvl == '0) begin
         span = '0;
      end else if (int'(lvl) > BLK_W) begin
         span = NBLK_V;
      end else begin
         span = SPAN_W'(1) << (lvl - LVL_W'(1));
      end
   end

   if (FROM_TOP) begin : g_top
      assign blk_hit = (span != '0) && (blk_ext >= (NBLK_V - span));
   end else begin : g_bottom
      assign blk_hit = blk_ext < span;
   end

   always_comb begin
      assert_no_hit_when_clear_R11: assert (lvl_any || !blk_hit);
   end

endmodule

// File: rtl/fsr_persist_bits.sv
module fsr_persist_bits
   import fsr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             lock_d,
   input  logic             qsel_d,
   input  logic [LVL_W-1:0] lvl_d,
   output logic             lock_q,
   output logic             qsel_q,
   output logic [LVL_W-1:0] lvl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         qsel_q <= 1'b0;
         lvl_q  <= '0;
      end else if (wr_en) begin
         lock_q <= lock_d;
         qsel_q <= qsel_d;
         lvl_q  <= lvl_d;
      end
   end

   assert_frozen_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({lock_q, qsel_q, lvl_q}));

   assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ({lock_q, qsel_q, lvl_q} == $past({lock_d, qsel_d, lvl_d})));

endmodule

// File: rtl/fsr_wel_wip.sv
module fsr_wel_wip (
   input  logic clk,
   input  logic rst_n,
   input  logic wel_set,
   input  logic wel_clr,
   input  logic op_start,
   input  logic eng_done,
   output logic wel_q,
   output logic wip_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
         wip_q <= 1'b0;
      end else if (wip_q) begin
         if (eng_done) begin
            wip_q <= 1'b0;
            wel_q <= 1'b0;
         end
      end else if (op_start) begin
         wip_q <= 1'b1;
      end else if (wel_set) begin
         wel_q <= 1'b1;
      end else if (wel_clr) begin
         wel_q <= 1'b0;
      end
   end

   assert_start_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> wip_q);

   assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wip_q && eng_done) |=> (!wip_q && !wel_q));

   assert_busy_holds_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wip_q && !eng_done) |=> (wip_q && $stable(wel_q)));

   assert_latch_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wip_q && !op_start && wel_set) |=> wel_q);

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
   import fsr_pkg::*;
#(
   parameter int BLK_W            = 5,
   parameter bit PROTECT_FROM_TOP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cmd_op,
   input  logic [7:0]       cmd_data,
   input  logic [BLK_W-1:0] cmd_blk,
   input  logic             wp_n,
   input  logic             eng_done,
   output logic [7:0]       sr_rd,
   output logic [5:0]       grant_vec,
   output logic             refuse,
   output logic             io23_data_mode
);

   if (WOP_N != 6 || SR_W != 8) begin : g_bad_layout
      $error("flash_status_ctrl: package layout does not match ports");
   end

   logic             lock_q, qsel_q;
   logic [LVL_W-1:0] lvl_q;
   logic             wel_q, wip_q;
   logic             lvl_any, blk_hit;
   logic             wp_eff_n, hw_lock;
   logic [WOP_N-1:0] req_vec, allow_vec;
   logic             op_start;

   // which write-type op is requested
   for (genvar gi = 0; gi < WOP_N; gi++) begin : g_req
      assign req_vec[gi] = (cmd_op == gidx_to_op(gi));
   end

   fsr_prot_decode #(
      .BLK_W    (BLK_W),
      .FROM_TOP (PROTECT_FROM_TOP)
   ) u_prot (
      .lvl     (lvl_q),
      .blk     (cmd_blk),
      .lvl_any (lvl_any),
      .blk_hit (blk_hit)
   );

   // in quad mode the pin is a data line and cannot hold the lock
   assign wp_eff_n = qsel_q | wp_n;
   assign hw_lock  = lock_q & ~wp_eff_n;

   always_comb begin
      allow_vec          = '0;
      allow_vec[GI_STAT] = !hw_lock;
      allow_vec[GI_CFG]  = 1'b1;
      allow_vec[GI_PROG] = !blk_hit;
      allow_vec[GI_SECT] = !blk_hit;
      allow_vec[GI_BLK]  = !blk_hit;
      allow_vec[GI_CHIP] = !lvl_any;
   end

   assign grant_vec = req_vec & allow_vec & {WOP_N{wel_q & ~wip_q}};
   assign refuse    = (|req_vec) & ~(|grant_vec);
   assign op_start  = |grant_vec;

   fsr_persist_bits u_persist (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (grant_vec[GI_STAT]),
      .lock_d (cmd_data[SB_LOCK]),
      .qsel_d (cmd_data[SB_QSEL]),
      .lvl_d  (cmd_data[SB_LVL_LO +: LVL_W]),
      .lock_q (lock_q),
      .qsel_q (qsel_q),
      .lvl_q  (lvl_q)
   );

   fsr_wel_wip u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wel_set  (cmd_op == OP_WEL_SET),
      .wel_clr  (cmd_op == OP_WEL_CLR),
      .op_start (op_start),
      .eng_done (eng_done),
      .wel_q    (wel_q),
      .wip_q    (wip_q)
   );

   always_comb begin
      sr_rd                         = '0;
      sr_rd[SB_LOCK]                = lock_q;
      sr_rd[SB_QSEL]                = qsel_q;
      sr_rd[SB_LVL_LO +: LVL_W]     = lvl_q;
      sr_rd[SB_WEL]                 = wel_q;
      sr_rd[SB_WIP]                 = wip_q;
   end

   assign io23_data_mode = qsel_q;

   assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));

   assert_grant_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vec != '0) |-> (sr_rd[SB_WEL] && !sr_rd[SB_WIP]));

   assert_chip_needs_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vec[GI_CHIP] |-> (sr_rd[SB_LVL_LO +: LVL_W] == '0));

   assert_lock_blocks_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_rd[SB_LOCK] && !sr_rd[SB_QSEL] && !wp_n) |-> !grant_vec[GI_STAT]);

   assert_refuse_keeps_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (refuse && !eng_done) |=> $stable(sr_rd[SB_WEL]));

   assert_no_start_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> !wip_q);

endmodule

// File: tb/flash_status_ctrl_tb.sv
module flash_status_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 44;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cmd_op = '0;
   logic [7:0] cmd_data = '0;
   logic [4:0] cmd_blk = '0;
   logic       wp_n = 1'b1;
   logic       eng_done = 1'b0;
   logic [7:0] sr_rd;
   logic [5:0] grant_vec;
   logic       refuse;
   logic       io23_data_mode;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_status_ctrl u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_op         (cmd_op),
      .cmd_data       (cmd_data),
      .cmd_blk        (cmd_blk),
      .wp_n           (wp_n),
      .eng_done       (eng_done),
      .sr_rd          (sr_rd),
      .grant_vec      (grant_vec),
      .refuse         (refuse),
      .io23_data_mode (io23_data_mode)
   );

   // {op, data, blk, wp_n, done, exp grant, exp refuse, exp status after edge, req}
   localparam logic [37:0] VEC [NV] = '{
      {4'd5, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b1, 8'h00, 4'd4},  // R4 latch clear
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h02, 4'd3},  // R3
      {4'd2, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h00, 4'd3},  // R3
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h02, 4'd3},  // R3
      {4'd5, 8'h00, 5'd3,  1'b1, 1'b0, 6'b000100, 1'b0, 8'h03, 4'd5},  // R5
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h03, 4'd6},  // R6
      {4'd6, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b1, 8'h03, 4'd6},  // R6
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h00, 4'd5},  // R5
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h02, 4'd3},
      {4'd3, 8'h0F, 5'd0,  1'b1, 1'b0, 6'b000001, 1'b0, 8'h0F, 4'd7},  // R7 low bits ignored
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h0C, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h0E, 4'd3},
      {4'd6, 8'h00, 5'd28, 1'b1, 1'b0, 6'b000000, 1'b1, 8'h0E, 4'd11}, // R11 R12
      {4'd6, 8'h00, 5'd27, 1'b1, 1'b0, 6'b001000, 1'b0, 8'h0F, 4'd11}, // R11
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h0C, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h0E, 4'd3},
      {4'd8, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b1, 8'h0E, 4'd10}, // R10
      {4'd3, 8'h80, 5'd0,  1'b1, 1'b0, 6'b000001, 1'b0, 8'h83, 4'd7},  // R7
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h80, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h82, 4'd3},
      {4'd3, 8'h00, 5'd0,  1'b0, 1'b0, 6'b000000, 1'b1, 8'h82, 4'd8},  // R8 locked
      {4'd3, 8'hC0, 5'd0,  1'b1, 1'b0, 6'b000001, 1'b0, 8'hC3, 4'd8},  // R8 pin high
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'hC0, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'hC2, 4'd3},
      {4'd3, 8'h94, 5'd0,  1'b0, 1'b0, 6'b000001, 1'b0, 8'h97, 4'd9},  // R9 quad overrides pin
      {4'd0, 8'h00, 5'd0,  1'b0, 1'b1, 6'b000000, 1'b0, 8'h94, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h96, 4'd3},
      {4'd7, 8'h00, 5'd15, 1'b1, 1'b0, 6'b010000, 1'b0, 8'h97, 4'd11}, // R11
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h94, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h96, 4'd3},
      {4'd7, 8'h00, 5'd16, 1'b1, 1'b0, 6'b000000, 1'b1, 8'h96, 4'd11}, // R11
      {4'd4, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000010, 1'b0, 8'h97, 4'd4},  // R4
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h94, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h96, 4'd3},
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h96, 4'd5},  // R5 idle done
      {4'd3, 8'h18, 5'd0,  1'b1, 1'b0, 6'b000001, 1'b0, 8'h1B, 4'd7},  // R7
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h18, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h1A, 4'd3},
      {4'd5, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b1, 8'h1A, 4'd11}, // R11 level 6
      {4'd3, 8'h00, 5'd0,  1'b0, 1'b0, 6'b000001, 1'b0, 8'h03, 4'd8},  // R8 lock off
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h00, 4'd5},
      {4'd1, 8'h00, 5'd0,  1'b1, 1'b0, 6'b000000, 1'b0, 8'h02, 4'd3},
      {4'd8, 8'h00, 5'd0,  1'b1, 1'b0, 6'b100000, 1'b0, 8'h03, 4'd10}, // R10
      {4'd0, 8'h00, 5'd0,  1'b1, 1'b1, 6'b000000, 1'b0, 8'h00, 4'd5}   // R2 layout throughout
   };

   task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (2) @(negedge clk);
      // R1 reset state
      check("reset status", 1, sr_rd, 8'h00);
      check("reset io mode", 1, {7'd0, io23_data_mode}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cmd_op   = VEC[i][37:34];
         cmd_data = VEC[i][33:26];
         cmd_blk  = VEC[i][25:21];
         wp_n     = VEC[i][20];
         eng_done = VEC[i][19];
         #1;
         check($sformatf("vec %0d grant", i), int'(VEC[i][3:0]), {2'b00, grant_vec}, {2'b00, VEC[i][18:13]});
         check($sformatf("vec %0d refuse", i), int'(VEC[i][3:0]), {7'd0, refuse}, {7'd0, VEC[i][12]});
         @(posedge clk);
         #1;
         check($sformatf("vec %0d status", i), int'(VEC[i][3:0]), sr_rd, VEC[i][11:4]);
      end

      // R9 quad select drives the pin mode output
      @(negedge clk); cmd_op = 4'd1; eng_done = 1'b0; wp_n = 1'b1;
      @(negedge clk); cmd_op = 4'd3; cmd_data = 8'h40;
      @(negedge clk); cmd_op = 4'd0;
      check("quad select pin mode", 9, {7'd0, io23_data_mode}, 8'h01);
      check("quad select status", 2, sr_rd, 8'h43);
      eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      check("quad after done", 5, sr_rd, 8'h40);
      // latch set, then reset returns all to zero
      cmd_op = 4'd1;
      @(negedge clk); cmd_op = 4'd0;
      check("latch before reset", 3, sr_rd, 8'h42);
      rst_n = 1'b0;
      #1;
      check("async reset status", 1, sr_rd, 8'h00);
      check("async reset io mode", 1, {7'd0, io23_data_mode}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 R11 with level 0 and latch set: erase to top block granted
      @(negedge clk); cmd_op = 4'd1;
      @(negedge clk); cmd_op = 4'd6; cmd_blk = 5'd31;
      #1;
      check("top block open at level 0", 11, {2'b00, grant_vec}, 8'h08);
      @(negedge clk); cmd_op = 4'd0;

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule